// File: doc/BRIEF.md
# ADC Channel-Gain Scan Table

This block sits in front of an analog-to-digital converter. It chooses the input channel, the gain step, the reference and the input mode for every conversion. The host builds an ordered list of packed entries by clearing the list and appending entries one at a time. Every conversion strobe then moves to the next entry, and the pointer returns to the first entry after the last one. A single-entry latch register covers single-channel work. The table-enable input chooses whether the list or the latch drives the multiplexer-control outputs.

The host can return the pointer to the first entry at any time, and it can freeze the pointer with a pause input. Each time the pointer wraps back to the first entry, the block raises a one-cycle scan-start pulse. Downstream logic can use this pulse to mark scan boundaries.

Top module: `cg_scan_table`

## Requirements
- R1: After a synchronous active-low reset, the list is empty, the pointer is 0, the latch entry is 0, all decoded outputs are 0 and `scan_start` is low.
- R2: An entry is 11 bits wide. Bits [3:0] are the channel, bits [6:4] are the gain step, bit 7 selects the external analog common reference, bits [9:8] are the range code (0 = ±5 V, 1 = ±10 V, 2 = 0 to 10 V) and bit 10 selects differential input. The outputs present these fields of the active entry.
- R3: With `tbl_en` low, the latch entry drives the outputs. A `latch_wr` pulse loads `latch_data`, and the new value is visible from the following cycle.
- R4: Each `tbl_wr` pulse appends one entry at the end of the list. The list holds at most DEPTH entries, and a write to a full list changes nothing.
- R5: `tbl_clear` empties the list and returns the pointer to 0. It wins over a `tbl_wr` in the same cycle. With `tbl_en` high and an empty list, the latch entry drives the outputs.
- R6: With `tbl_en` high and a non-empty list, each `conv_strobe` moves the pointer one entry forward. After the last stored entry, the pointer returns to entry 0.
- R7: `scan_start` is high for exactly the one cycle in which the pointer has just wrapped to 0. A pointer reset or a clear does not raise it.
- R8: `ptr_reset` returns the pointer to entry 0 and wins over a `conv_strobe` in the same cycle.
- R9: While `pause_en` is high, conversion strobes leave the pointer unchanged.
- R10: While `tbl_en` is low, conversion strobes leave the table pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_clear | input | 1 | Empty the list and zero the pointer |
| tbl_wr | input | 1 | Append `tbl_wr_data` to the list |
| tbl_wr_data | input | 11 | Packed entry to append |
| tbl_en | input | 1 | 1: list drives outputs, 0: latch entry drives outputs |
| latch_wr | input | 1 | Load the latch entry |
| latch_data | input | 11 | Packed latch entry |
| ptr_reset | input | 1 | Return pointer to entry 0 |
| pause_en | input | 1 | Hold the pointer |
| conv_strobe | input | 1 | One pulse per conversion |
| out_chan | output | 4 | Active channel |
| out_gain | output | 3 | Active gain step |
| out_ext_ref | output | 1 | External analog common reference selected |
| out_range | output | 2 | Active range code |
| out_diff | output | 1 | Differential input selected |
| scan_start | output | 1 | One-cycle pulse when the pointer wraps to 0 |

## Verification
The embedded assertions check the following on every cycle:
- the fill count never goes above DEPTH;
- a clear empties the list, and an append adds exactly one entry;
- a write to a full list is dropped;
- the pointer stays below the fill count;
- a pointer reset lands on 0, and a pause holds the pointer;
- `scan_start` appears only when the pointer is at 0.

Only the bench scenarios can show that the right entry contents reach the outputs, in the right order. The bench sweeps every fill level from one entry to a full list and checks each wrap period against arithmetic expectations. It also checks which source the outputs show under latch mode, an empty list, and simultaneous clear-with-write or reset-with-strobe.

// File: rtl/cg_scan_pkg.sv
`timescale 1ns/1ps
// Package: shared packed entry layout for the channel-gain scan table.
// Assumes the field positions are fixed, because the front-end decodes them.
package cg_scan_pkg;
    localparam int ENTRY_W = 11;

    // Field order from MSB to LSB matches the bit positions of one entry.
    typedef struct packed {
        logic       diff;      // bit 10: differential input
        logic [1:0] range_sel; // bits 9:8: range code
        logic       ext_ref;   // bit 7: external analog common
        logic [2:0] gain;      // bits 6:4: gain step
        logic [3:0] chan;      // bits 3:0: channel
    } cg_entry_t;
endpackage

// File: rtl/cg_entry_store.sv
`timescale 1ns/1ps
// Module: entry storage with an append-only write position.
// Holds up to DEPTH entries. A clear sets the fill count to zero, and a write
// fills the slot at the current fill count. Assumes the reader only addresses
// slots below the fill count, so the slots themselves carry no reset.
module cg_entry_store
    import cg_scan_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          wr_i,
    input  cg_entry_t     wr_data_i,
    input  logic [IW-1:0] rd_idx_i,
    output logic [CW-1:0] count_o,
    output cg_entry_t     rd_data_o
);
    cg_entry_t     mem_q [DEPTH];
    logic [CW-1:0] count_q;
    logic          wr_ok;

    // Accept a write only when it is not cleared and the list has room.
    assign wr_ok = wr_i && !clear_i && (count_q < CW'(DEPTH));

    // Fill count: clear has priority, then append.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (clear_i) count_q <= '0;
        else if (wr_ok)   count_q <= count_q + CW'(1);
    end

    // Entry slots: write the slot at the current end of the list.
    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[count_q[IW-1:0]] <= wr_data_i;
    end

    assign count_o   = count_q;
    assign rd_data_o = mem_q[rd_idx_i];

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));
    // R4
    append_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clear_i && count_q < CW'(DEPTH)) |=> count_q == $past(count_q) + CW'(1));
    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clear_i && count_q == CW'(DEPTH)) |=> count_q == CW'(DEPTH));
    // R5
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> count_q == '0);
endmodule

// File: rtl/cg_scan_pointer.sv
`timescale 1ns/1ps
// Module: read pointer over the stored list.
// Moves one step on each unpaused advance and wraps to 0 after the last
// stored entry. A wrap produces a one-cycle registered scan-start flag.
// Assumes the fill count only shrinks through clear_i, which also zeroes the
// pointer.
module cg_scan_pointer #(
    parameter int DEPTH = 16,
    parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          ptr_reset_i,
    input  logic          pause_i,
    input  logic          advance_i,
    input  logic [CW-1:0] count_i,
    output logic [IW-1:0] ptr_o,
    output logic          wrap_o
);
    logic [IW-1:0] ptr_q;
    logic          wrap_q;
    logic          at_last;
    logic          step;

    // The pointer is on the final stored entry.
    assign at_last = (CW'(ptr_q) + CW'(1)) == count_i;
    // A step needs an advance request, no pause and a non-empty list.
    assign step    = advance_i && !pause_i && (count_i != '0);

    // Pointer and wrap flag: clear and reset win, then step or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= 1'b0;
            if (clear_i || ptr_reset_i) begin
                ptr_q <= '0;
            end else if (step) begin
                if (at_last) begin
                    ptr_q  <= '0;
                    wrap_q <= 1'b1;
                end else begin
                    ptr_q <= ptr_q + IW'(1);
                end
            end
        end
    end

    assign ptr_o  = ptr_q;
    assign wrap_o = wrap_q;

    // R6
    ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i != '0) |-> CW'(ptr_q) < count_i);
    // R8
    ptr_reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_reset_i |=> ptr_q == '0);
    // R9
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_i && !ptr_reset_i && !clear_i) |=> $stable(ptr_q));
    // R7
    scan_start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |-> ptr_q == '0);
    // R7
    scan_start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |=> !wrap_q || $past(step));
endmodule

// File: rtl/cg_source_select.sv
`timescale 1ns/1ps
// Module: single-entry latch register and active-source multiplexer.
// The table supplies the active entry only when table mode is on and the list
// holds at least one entry. Otherwise the latch entry is active.
module cg_source_select
    import cg_scan_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          latch_wr_i,
    input  cg_entry_t     latch_data_i,
    input  logic          tbl_en_i,
    input  logic [CW-1:0] count_i,
    input  cg_entry_t     tbl_entry_i,
    output cg_entry_t     active_o
);
    cg_entry_t latch_q;

    // Latch register: load on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)          latch_q <= '0;
        else if (latch_wr_i) latch_q <= latch_data_i;
    end

    // Source choice: table when enabled and non-empty, else latch.
    always_comb begin
        if (tbl_en_i && (count_i != '0)) active_o = tbl_entry_i;
        else                             active_o = latch_q;
    end

    // R3
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_wr_i && !tbl_en_i) |=> !tbl_en_i || active_o == $past(latch_data_i) || count_i != '0);
endmodule

// File: rtl/cg_scan_table.sv
`timescale 1ns/1ps
// Module: ADC channel-gain scan table (top).
// Presents the active packed entry, decoded into fields, to the front-end
// multiplexer. Conversion strobes walk the stored list only in table mode.
// Assumes all inputs are synchronous to clk and each control pulse lasts one
// cycle.
module cg_scan_table
    import cg_scan_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tbl_clear,
    input  logic        tbl_wr,
    input  logic [10:0] tbl_wr_data,
    input  logic        tbl_en,
    input  logic        latch_wr,
    input  logic [10:0] latch_data,
    input  logic        ptr_reset,
    input  logic        pause_en,
    input  logic        conv_strobe,
    output logic [3:0]  out_chan,
    output logic [2:0]  out_gain,
    output logic        out_ext_ref,
    output logic [1:0]  out_range,
    output logic        out_diff,
    output logic        scan_start
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] count;
    logic [IW-1:0] ptr;
    cg_entry_t     tbl_entry;
    cg_entry_t     active;

    cg_entry_store #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (tbl_clear),
        .wr_i      (tbl_wr),
        .wr_data_i (cg_entry_t'(tbl_wr_data)),
        .rd_idx_i  (ptr),
        .count_o   (count),
        .rd_data_o (tbl_entry)
    );

    cg_scan_pointer #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (tbl_clear),
        .ptr_reset_i (ptr_reset),
        .pause_i     (pause_en),
        .advance_i   (conv_strobe && tbl_en),
        .count_i     (count),
        .ptr_o       (ptr),
        .wrap_o      (scan_start)
    );

    cg_source_select #(.CW(CW)) u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .latch_wr_i   (latch_wr),
        .latch_data_i (cg_entry_t'(latch_data)),
        .tbl_en_i     (tbl_en),
        .count_i      (count),
        .tbl_entry_i  (tbl_entry),
        .active_o     (active)
    );

    // Field decode of the active entry.
    assign out_chan    = active.chan;
    assign out_gain    = active.gain;
    assign out_ext_ref = active.ext_ref;
    assign out_range   = active.range_sel;
    assign out_diff    = active.diff;
endmodule

// File: tb/test_cg_scan_table.sv
`timescale 1ns/1ps
module test_cg_scan_table;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tbl_clear = 0, tbl_wr = 0, tbl_en = 0, latch_wr = 0;
    logic ptr_reset = 0, pause_en = 0, conv_strobe = 0;
    logic [10:0] tbl_wr_data = '0, latch_data = '0;
    logic [3:0] out_chan;
    logic [2:0] out_gain;
    logic out_ext_ref, out_diff, scan_start;
    logic [1:0] out_range;
    logic [10:0] word;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cg_scan_table #(.DEPTH(DEPTH)) i_cg_scan_table (
        .clk(clk), .rst_n(rst_n), .tbl_clear(tbl_clear), .tbl_wr(tbl_wr),
        .tbl_wr_data(tbl_wr_data), .tbl_en(tbl_en), .latch_wr(latch_wr),
        .latch_data(latch_data), .ptr_reset(ptr_reset), .pause_en(pause_en),
        .conv_strobe(conv_strobe), .out_chan(out_chan), .out_gain(out_gain),
        .out_ext_ref(out_ext_ref), .out_range(out_range), .out_diff(out_diff),
        .scan_start(scan_start)
    );

    assign word = {out_diff, out_range, out_ext_ref, out_gain, out_chan};

    function automatic logic [10:0] ent(int i, int n);
        return 11'((i * 173 + n * 59 + 7) % 2048);
    endfunction

    task automatic chk(string req, logic [10:0] got, logic [10:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [10:0] d);
        @(negedge clk); tbl_wr = 1; tbl_wr_data = d;
        @(negedge clk); tbl_wr = 0;
    endtask

    task automatic clr();
        @(negedge clk); tbl_clear = 1;
        @(negedge clk); tbl_clear = 0;
    endtask

    task automatic strobe();
        @(negedge clk); conv_strobe = 1;
        @(negedge clk); conv_strobe = 0;
    endtask

    task automatic fill(int n);
        clr();
        for (int i = 0; i < n; i++) wr(ent(i, n));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog got=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", word, 11'h000);
        chk("R1 scan_start", {10'b0, scan_start}, 11'h000);

        // R2 / R3: one-hot latch sweep, field by field
        tbl_en = 0;
        for (int b = 0; b < 11; b++) begin
            @(negedge clk); latch_wr = 1; latch_data = 11'(1 << b);
            @(negedge clk); latch_wr = 0;
            chk("R2 chan", {7'b0, out_chan}, {7'b0, latch_data[3:0]});
            chk("R2 gain", {8'b0, out_gain}, {8'b0, latch_data[6:4]});
            chk("R2 ext_ref", {10'b0, out_ext_ref}, {10'b0, latch_data[7]});
            chk("R2 range", {9'b0, out_range}, {9'b0, latch_data[9:8]});
            chk("R2 diff", {10'b0, out_diff}, {10'b0, latch_data[10]});
        end
        @(negedge clk); latch_wr = 1; latch_data = 11'h5A3;
        @(negedge clk); latch_wr = 0;
        chk("R3 latch mode", word, 11'h5A3);

        // R6 / R7: sweep every fill level
        tbl_en = 1;
        for (int n = 1; n <= DEPTH; n++) begin
            fill(n);
            chk("R4 first entry", word, ent(0, n));
            for (int s = 1; s <= 2 * n; s++) begin
                strobe();
                chk("R6 entry order", word, ent(s % n, n));
                chk("R7 scan_start", {10'b0, scan_start}, {10'b0, (s % n) == 0});
            end
            @(negedge clk);
            chk("R7 pulse width", {10'b0, scan_start}, 11'h000);
        end

        // R4: overfill, extra writes dropped
        fill(DEPTH);
        wr(11'h7FF); wr(11'h7FE);
        for (int s = 1; s < DEPTH; s++) strobe();
        chk("R4 last entry", word, ent(DEPTH - 1, DEPTH));
        strobe();
        chk("R4 full wrap", word, ent(0, DEPTH));
        chk("R4 full wrap pulse", {10'b0, scan_start}, 11'h001);

        // R5: clear with a simultaneous write, then empty list shows latch
        @(negedge clk); tbl_clear = 1; tbl_wr = 1; tbl_wr_data = 11'h123;
        @(negedge clk); tbl_clear = 0; tbl_wr = 0;
        chk("R5 empty shows latch", word, 11'h5A3);
        wr(11'h3C4);
        chk("R5 append after clear", word, 11'h3C4);

        // R8: pointer reset, and reset over strobe
        fill(5);
        strobe(); strobe(); strobe();
        chk("R8 pre reset", word, ent(3, 5));
        @(negedge clk); ptr_reset = 1;
        @(negedge clk); ptr_reset = 0;
        chk("R8 reset to 0", word, ent(0, 5));
        chk("R8 no scan_start", {10'b0, scan_start}, 11'h000);
        strobe(); strobe();
        @(negedge clk); ptr_reset = 1; conv_strobe = 1;
        @(negedge clk); ptr_reset = 0; conv_strobe = 0;
        chk("R8 reset beats strobe", word, ent(0, 5));

        // R9: pause
        strobe(); strobe();
        pause_en = 1;
        strobe(); strobe(); strobe();
        chk("R9 paused", word, ent(2, 5));
        pause_en = 0;
        strobe();
        chk("R9 resumed", word, ent(3, 5));

        // R10: strobes in latch mode
        tbl_en = 0;
        strobe(); strobe(); strobe();
        chk("R10 latch output", word, 11'h5A3);
        chk("R10 no scan_start", {10'b0, scan_start}, 11'h000);
        @(negedge clk); tbl_en = 1;
        @(negedge clk);
        chk("R10 pointer held", word, ent(3, 5));

        // R5: clear zeroes the pointer
        fill(3);
        chk("R5 pointer zeroed", word, ent(0, 3));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule